// File: doc/BRIEF.md
# Serial Command Front End for Nonvolatile Memory

This block is the serial slave interface that sits in front of an on-chip nonvolatile memory. A host frames each transaction with an active-low chip select, clocks eight-bit opcodes in on a data line with the most significant bit first, and receives replies on a separate data line that is released to high impedance whenever the slave is not talking. The interface inputs are brought into the system clock domain through synchronizer chains, and every action is taken on the detected edges of the serial clock.

The slave keeps an eight-bit status word. One bit is a write-enable latch that the host sets or clears with single-byte opcodes. The latch drives a write-permission output for the memory controller. A second bit mirrors a busy flag that comes back from that controller. A third opcode returns the whole status word, reserved upper bits included. When a single-byte command has finished, the slave ignores all further serial traffic until chip select is raised. A transaction that ends early changes nothing.

Top module: `spi_nvm_cmd_slave`

## Requirements
- R1: Opcode bits are sampled on rising serial-clock edges and assembled most significant bit first, so the bit-reversed pattern 0x60 does not act as opcode 0x06.
- R2: Opcode 0x06 sets the write-enable latch, and `wr_allow` goes to 1.
- R3: Opcode 0x04 clears the write-enable latch, and `wr_allow` goes to 0.
- R4: Once a set or clear opcode has completed, any further bits in the same transaction are ignored until `cs_n` rises.
- R5: While opcode bits are being received, `sdo_oe` stays 0.
- R6: Opcode 0x05 returns the eight-bit status word on `sdo`, most significant bit first, one bit per falling serial-clock edge, with bits 7..2 all 0 and bit 1 equal to the write-enable latch.
- R7: After the eighth status bit has been sent, the next falling edge sets `sdo_oe` to 0, and further clocks in that transaction produce no output.
- R8: Raising `cs_n` before the eighth opcode bit leaves the write-enable latch unchanged.
- R9: Any opcode other than 0x04, 0x05 or 0x06 changes nothing and puts the slave into the ignore state.
- R10: `sdo_oe` is 0 whenever `cs_n` is high, including when `cs_n` rises in the middle of a status readout.
- R11: Status bit 0 carries `busy_in` as it was when the read opcode completed.
- R12: If `cs_n` rises in the same clock cycle as the eighth rising serial-clock edge, the transaction is aborted and the latch is unchanged. The next transaction works normally.
- R13: After reset the write-enable latch is 0 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| busy_in | input | 1 | Busy flag from the memory controller |
| sdo | output | 1 | Serial reply data, valid while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver; 0 means high impedance |
| wr_allow | output | 1 | Write permission to the memory controller (the write-enable latch) |

## Verification
Two events can arrive in the same system cycle: a transaction abort caused by chip select rising, and the decode of a completed opcode triggered by the eighth serial-clock rise. The bench provokes this by raising `cs_n` and `sck` together on one falling system-clock edge, so that both pass through equal-length synchronizers. It judges the outcome by the fact that the latch keeps its old value, read on `wr_allow`, and that a status read issued afterwards returns the expected word. The monitor also flags any status byte that is left partly shifted when chip select rises, unless the bench aborted that readout on purpose.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and types for the serial memory command slave.
// Assumes one-byte opcodes and an eight-bit status word.
package spi_cmd_pkg;
    parameter int CMD_W = 8;

    localparam logic [CMD_W-1:0] OPC_SET_WE  = 8'h06;
    localparam logic [CMD_W-1:0] OPC_CLR_WE  = 8'h04;
    localparam logic [CMD_W-1:0] OPC_RD_STAT = 8'h05;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_WE_BIT   = 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // chip select inactive
        PH_CMD  = 2'd1,   // receiving opcode bits
        PH_READ = 2'd2,   // returning the status word
        PH_HOLD = 2'd3    // ignoring traffic until chip select rises
    } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings cs_n, sck and sdi into the clk domain and finds the sck edges.
// Assumes clk runs at least four times faster than sck. All lanes have
// the same depth, so pins that change together are seen in the same cycle.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s
);
    localparam int LANES = 3;
    localparam logic [LANES-1:0] LANE_RST = 3'b100;  // chip select idles high

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic             sck_d;

    assign raw = {cs_n, sck, sdi};

    for (genvar i = 0; i < LANES; i++) begin : gen_lane
        logic [STAGES-1:0] q;
        // Purpose: shift the pin through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= {STAGES{LANE_RST[i]}};
            else        q <= {q[STAGES-2:0], raw[i]};
        end
        assign synced[i] = q[STAGES-1];
    end

    // Purpose: hold the previous synchronized sck for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= synced[1];
    end

    assign cs_act   = ~synced[2];
    assign sck_rise = synced[1] & ~sck_d;
    assign sck_fall = ~synced[1] & sck_d;
    assign sdi_s    = synced[0];
endmodule

// File: rtl/spi_cmd_rx.sv
// Assembles an opcode MSB first and flags the cycle in which its last bit
// arrives. The bit counter clears while chip select is inactive.
module spi_cmd_rx #(
    parameter int W = spi_cmd_pkg::CMD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_act,
    input  logic         shift_en,
    input  logic         sdi_s,
    output logic         done,
    output logic [W-1:0] code
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-2:0]  sh_q;
    logic [CW-1:0] cnt_q;

    // Purpose: shift in one bit per accepted rising edge and count bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (!cs_act) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            sh_q  <= {sh_q[W-3:0], sdi_s};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign done = shift_en && (cnt_q == LAST);
    assign code = {sh_q, sdi_s};

    // R1: a completed opcode always follows exactly W-1 earlier accepted bits
    p_full_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_act && (cnt_q == LAST));
endmodule

// File: rtl/spi_cmd_ctrl.sv
// Phase machine and write-enable latch. It decodes completed opcodes,
// starts the status readout and locks into the hold phase. A chip select
// release overrides any decode in the same cycle.
module spi_cmd_ctrl
    import spi_cmd_pkg::*;
#(
    parameter int W = CMD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_act,
    input  logic         done,
    input  logic [W-1:0] code,
    input  logic         tx_finish,
    output logic         take_bit,
    output logic         load_tx,
    output logic         wen,
    output phase_t       phase
);
    assign take_bit = cs_act && (phase == PH_IDLE || phase == PH_CMD);
    assign load_tx  = take_bit && done && (code == OPC_RD_STAT);

    // Purpose: advance the transaction phase and update the latch on decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            wen   <= 1'b0;
        end else if (!cs_act) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE, PH_CMD: begin
                    if (done) begin
                        if (code == OPC_SET_WE) begin
                            wen   <= 1'b1;
                            phase <= PH_HOLD;
                        end else if (code == OPC_CLR_WE) begin
                            wen   <= 1'b0;
                            phase <= PH_HOLD;
                        end else if (code == OPC_RD_STAT) begin
                            phase <= PH_READ;
                        end else begin
                            phase <= PH_HOLD;
                        end
                    end else begin
                        phase <= PH_CMD;
                    end
                end
                PH_READ: if (tx_finish) phase <= PH_HOLD;
                PH_HOLD: phase <= PH_HOLD;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R4: the latch moves only while an opcode is being received
    p_latch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ || phase == PH_HOLD) |=> $stable(wen));
    // R4: the hold phase lasts until chip select goes inactive
    p_hold_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && cs_act) |=> (phase == PH_HOLD));
    // R8: an inactive chip select never changes the latch
    p_abort_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> $stable(wen));
endmodule

// File: rtl/spi_stat_tx.sv
// Shifts a snapshot of the status word out MSB first, one bit per falling
// sck edge, then releases the line on the following falling edge.
module spi_stat_tx #(
    parameter int W = spi_cmd_pkg::CMD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_act,
    input  logic         load,
    input  logic [W-1:0] status,
    input  logic         sck_fall,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         finish
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    logic [W-1:0]  tx_q;
    logic [CW-1:0] cnt_q;
    logic          armed_q;

    assign finish = cs_act && !load && armed_q && sck_fall && (cnt_q == FULL);

    // Purpose: load the snapshot, then drive and shift one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else if (!cs_act) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            sdo_oe  <= 1'b0;
        end else if (load) begin
            tx_q    <= status;
            cnt_q   <= '0;
            armed_q <= 1'b1;
            sdo_oe  <= 1'b0;
        end else if (armed_q && sck_fall) begin
            if (cnt_q == FULL) begin
                armed_q <= 1'b0;
                sdo_oe  <= 1'b0;
                sdo     <= 1'b0;
            end else begin
                sdo    <= tx_q[W-1];
                tx_q   <= {tx_q[W-2:0], 1'b0};
                cnt_q  <= cnt_q + 1'b1;
                sdo_oe <= 1'b1;
            end
        end
    end

    // R6: the line is only driven while one of the W bits is being presented
    p_bit_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (cnt_q >= 1) && (cnt_q <= FULL));
    // R7: after the release edge the line stays quiet
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !sdo_oe);
endmodule

// File: rtl/spi_nvm_cmd_slave.sv
// Top level of the serial command slave: pin synchronizers, opcode receiver,
// phase controller and status transmitter. sdo and sdo_oe feed the pad's
// tristate driver. Assumes clk oversamples sck by at least four.
module spi_nvm_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int W           = CMD_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    input  logic busy_in,
    output logic sdo,
    output logic sdo_oe,
    output logic wr_allow
);
    logic         cs_act, sck_rise, sck_fall, sdi_s;
    logic         done, take_bit, load_tx, wen, tx_finish;
    logic [W-1:0] code;
    logic [W-1:0] status;
    phase_t       phase;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s)
    );

    spi_cmd_rx #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .shift_en(take_bit && sck_rise), .sdi_s(sdi_s),
        .done(done), .code(code)
    );

    spi_cmd_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .done(done), .code(code),
        .tx_finish(tx_finish), .take_bit(take_bit), .load_tx(load_tx),
        .wen(wen), .phase(phase)
    );

    // Purpose: compose the status word; reserved bits read as zero.
    always_comb begin
        status                = '0;
        status[STAT_WE_BIT]   = wen;
        status[STAT_BUSY_BIT] = busy_in;
    end

    spi_stat_tx #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .load(load_tx),
        .status(status), .sck_fall(sck_fall),
        .sdo(sdo), .sdo_oe(sdo_oe), .finish(tx_finish)
    );

    assign wr_allow = wen;

    // R10: an inactive chip select releases the line by the next cycle
    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo_oe);
    // R5: the line is driven only in the readout phase, never while receiving
    p_oe_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (phase == PH_READ));
endmodule

// File: tb/sim_spi_nvm_cmd_slave.sv
// Scoreboard bench: the read task pushes expected status bytes, and a
// monitor assembles driven bits on each sck rise and compares them.
module sim_spi_nvm_cmd_slave;
    localparam int HALF = 8;        // system cycles per sck half period
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, busy_in = 1'b0;
    logic sdo, sdo_oe, wr_allow;

    int n_chk = 0, n_bad = 0;
    logic [7:0] expq[$];
    logic [7:0] mon_byte = '0;
    int mon_n = 0;
    bit allow_partial = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_nvm_cmd_slave u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .busy_in(busy_in), .sdo(sdo), .sdo_oe(sdo_oe), .wr_allow(wr_allow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send bits MSB first; optionally check the line is released before each rise
    task automatic send_bits(input logic [7:0] v, input int nbits, input bit chk_oe);
        for (int i = 7; i > 7 - nbits; i--) begin
            sdi = v[i];
            wait_clk(HALF);
            if (chk_oe) check(sdo_oe == 1'b0, "R5", sdo_oe, 0);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic start_cs();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic end_cs();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic one_cmd(input logic [7:0] op);
        start_cs();
        send_bits(op, 8, 1'b1);
        end_cs();
    endtask

    task automatic rd_status(input logic [7:0] exp);
        expq.push_back(exp);
        start_cs();
        send_bits(8'h05, 8, 1'b1);
        sdi = 1'b0;
        for (int k = 0; k < 10; k++) begin   // 8 status bits + 2 spare clocks
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        check(sdo_oe == 1'b0, "R7", sdo_oe, 0);
        end_cs();
    endtask

    // monitor: collect driven bits on sck rise and compare whole bytes
    always @(posedge sck) begin
        if (sdo_oe === 1'b1) begin
            mon_byte = {mon_byte[6:0], sdo};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (expq.size() == 0) check(1'b0, "R7", mon_byte, 0);
                else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    check(mon_byte == e, "R6", mon_byte, e);
                end
            end
        end
    end

    always @(posedge cs_n) begin
        if (mon_n != 0 && !allow_partial) check(1'b0, "R6", mon_n, 0);
        mon_n = 0;
    end

    initial begin
        for (int c = 0; c < WDOG && !finished; c++) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WDOG, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check(wr_allow == 1'b0, "R13", wr_allow, 0);
        check(sdo_oe == 1'b0, "R13", sdo_oe, 0);
        check(sdo_oe == 1'b0, "R10", sdo_oe, 0);

        // R1 / R9: bit-reversed pattern must not set the latch
        one_cmd(8'h60);
        check(wr_allow == 1'b0, "R1", wr_allow, 0);

        one_cmd(8'h06);
        check(wr_allow == 1'b1, "R2", wr_allow, 1);

        rd_status(8'h02);               // R6 with busy low
        busy_in = 1'b1;
        rd_status(8'h03);               // R11 busy in bit 0
        busy_in = 1'b0;

        // R4: trailing clear bits after set are ignored
        start_cs(); send_bits(8'h06, 8, 1'b1); send_bits(8'h04, 8, 1'b0); end_cs();
        check(wr_allow == 1'b1, "R4", wr_allow, 1);

        one_cmd(8'h04);
        check(wr_allow == 1'b0, "R3", wr_allow, 0);

        // R4: trailing set bits after clear are ignored
        start_cs(); send_bits(8'h04, 8, 1'b1); send_bits(8'h06, 8, 1'b0); end_cs();
        check(wr_allow == 1'b0, "R4", wr_allow, 0);

        // R8: seven bits of a set opcode, then abort
        start_cs(); send_bits(8'h06, 7, 1'b1); end_cs();
        check(wr_allow == 1'b0, "R8", wr_allow, 0);

        // R9: unknown opcode, and set opcode bits after it are ignored
        start_cs(); send_bits(8'hFF, 8, 1'b1); send_bits(8'h06, 8, 1'b0); end_cs();
        check(wr_allow == 1'b0, "R9", wr_allow, 0);
        one_cmd(8'h06);
        start_cs(); send_bits(8'hA5, 8, 1'b1); send_bits(8'h04, 8, 1'b0); end_cs();
        check(wr_allow == 1'b1, "R9", wr_allow, 1);
        rd_status(8'h02);

        // R10: abort in the middle of a readout
        allow_partial = 1'b1;
        start_cs();
        send_bits(8'h05, 8, 1'b1);
        for (int k = 0; k < 3; k++) begin
            wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
        end
        wait_clk(HALF);
        check(sdo_oe == 1'b1, "R10", sdo_oe, 1);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        check(sdo_oe == 1'b0, "R10", sdo_oe, 0);
        allow_partial = 1'b0;

        // R12: chip select rises with the eighth sck rise of a clear opcode
        start_cs();
        send_bits(8'h04, 7, 1'b1);
        sdi = 1'b0;
        wait_clk(HALF);
        sck = 1'b1;
        cs_n = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
        wait_clk(2 * HALF);
        check(wr_allow == 1'b1, "R12", wr_allow, 1);
        rd_status(8'h02);               // R12 recovery

        wait_clk(4);
        check(expq.size() == 0, "R6", expq.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule